// File: doc/BRIEF.md
# Shared Timer Clock Prescaler Selector

This block sits between a system clock and two timer channels. It turns the system clock into per-channel count-enable strobes, so the timers never run on a derived clock. A single 10-bit divider counts continuously. Four taps of it give strobes at 1/8, 1/64, 1/256 and 1/1024 of the system clock rate. Each channel has its own 3-bit select. The select picks between no counting, counting on every cycle, one of the four taps, or edges of an external level that an outside synchronizer has already brought into the clock domain.

The divider is shared. A select change on either channel does not touch it. A synchronous prescaler clear restarts it, which moves the tap phase for both channels at the same instant. Software uses the clear to line up a timer with program flow, but it must remember that the other channel shifts as well. Each output is a one-cycle strobe that a timer counter uses as its clock enable.

Top module: `timer_presc_share`

## Requirements
- R1: While `rst` is high every `cnt_en` bit is 0. The edge after `rst` is sampled leaves the divider at 0.
- R2: Select code 0 keeps that channel's `cnt_en` at 0 on every cycle.
- R3: Select code 1 drives that channel's `cnt_en` to 1 on every cycle out of reset.
- R4: Select codes 2, 3, 4 and 5 choose the taps of divisor 8, 64, 256 and 1024. Tap N strobes in each cycle where the divider value modulo N equals N-1. With the select held and no clear, this gives exactly one strobe every N cycles.
- R5: The divider advances by one (modulo 1024) on every clock edge where neither `rst` nor `presc_clr` is sampled high. This holds whatever either select does.
- R6: When a channel is switched onto tap N, its first strobe arrives within N cycles, counting the first cycle that shows the new select as cycle 1.
- R7: The edge that samples `presc_clr` high loads the divider with 0. For both channels, the first strobe of tap N is therefore the N-th cycle after that edge.
- R8: Code 7 strobes in the cycle in which `ext_lvl` is first seen high after being low. Code 6 strobes in the cycle in which it is first seen low after being high. The previous level is captured on every edge, including during reset, so releasing reset creates no false edge.
- R9: The two channels may hold different select codes at the same time. Each channel's output depends only on its own select and external level, together with the shared divider.
- R10: For codes 2 through 7, with the select unchanged, a strobe is never followed by another strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_clr | input | 1 | Synchronous restart of the shared divider |
| ch_sel | input | NUM_CH x 3 | Per-channel clock select code (0..7) |
| ext_lvl | input | NUM_CH | Per-channel external level, already synchronized to `clk` |
| cnt_en | output | NUM_CH | Per-channel one-cycle count-enable strobe |

## Verification
The assertions assume that `ext_lvl` and `ch_sel` change only between clock edges, that `ext_lvl` already belongs to the clock domain, and that reset is held for at least one edge at start-up. They do not require the external level to stay stable for any minimum time, because the edge detector works from the level seen at the previous edge. The stimulus changes every input half a period away from the sampling edge and starts with several reset cycles. It toggles the external levels at random, including back-to-back toggles, and it fires the prescaler clear and reset rarely enough that full 1024-cycle tap periods still occur between them.

// File: rtl/tpresc_pkg.sv
package tpresc_pkg;

  localparam int NUM_TAPS = 4;

  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIRECT   = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } csel_e;

  // number of low divider bits that make up tap idx
  function automatic int tap_bits(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // true when the low 'bits' bits of v are all ones (the tap is about to wrap)
  function automatic logic low_ones(input logic [15:0] v, input int bits);
    logic [15:0] m;
    m = 16'((32'd1 << bits) - 32'd1);
    return (v & m) == m;
  endfunction

endpackage

// File: rtl/presc_divider.sv
module presc_divider #(
  parameter int DIV_W    = 10,
  parameter int NUM_TAPS = tpresc_pkg::NUM_TAPS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  output logic [DIV_W-1:0]    cnt,
  output logic [NUM_TAPS-1:0] tap_stb
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap_stb[k] = tpresc_pkg::low_ones(16'(cnt), tpresc_pkg::tap_bits(k));
  end

endmodule

// File: rtl/presc_edge_det.sv
module presc_edge_det (
  input  logic clk,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  // captured on every edge, reset included, so reset release makes no edge
  always_ff @(posedge clk) prev_q <= lvl;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/presc_chan_sel.sv
module presc_chan_sel #(
  parameter int NUM_TAPS = tpresc_pkg::NUM_TAPS
) (
  input  logic                rst,
  input  logic [2:0]          sel,
  input  logic [NUM_TAPS-1:0] tap_stb,
  input  logic                ext_rise,
  input  logic                ext_fall,
  output logic                en
);
  import tpresc_pkg::*;

  csel_e code;
  assign code = csel_e'(sel);

  always_comb begin
    en = 1'b0;
    if (!rst) begin
      case (code)
        CS_OFF:      en = 1'b0;
        CS_DIRECT:   en = 1'b1;
        CS_DIV8:     en = tap_stb[0];
        CS_DIV64:    en = tap_stb[1];
        CS_DIV256:   en = tap_stb[2];
        CS_DIV1024:  en = tap_stb[NUM_TAPS-1];
        CS_EXT_FALL: en = ext_fall;
        CS_EXT_RISE: en = ext_rise;
        default:     en = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/timer_presc_share.sv
module timer_presc_share #(
  parameter int NUM_CH = 2,
  parameter int DIV_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   presc_clr,
  input  logic [NUM_CH-1:0][2:0] ch_sel,
  input  logic [NUM_CH-1:0]      ext_lvl,
  output logic [NUM_CH-1:0]      cnt_en
);
  localparam int NUM_TAPS = tpresc_pkg::NUM_TAPS;

  // named internal events, visible to the bound checker
  logic [DIV_W-1:0]    div_cnt;
  logic [NUM_TAPS-1:0] tap_stb;
  logic [NUM_CH-1:0]   ext_rise;
  logic [NUM_CH-1:0]   ext_fall;

  presc_divider #(.DIV_W(DIV_W), .NUM_TAPS(NUM_TAPS)) u_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (presc_clr),
    .cnt     (div_cnt),
    .tap_stb (tap_stb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    presc_edge_det u_edge (
      .clk  (clk),
      .lvl  (ext_lvl[c]),
      .rise (ext_rise[c]),
      .fall (ext_fall[c])
    );

    presc_chan_sel #(.NUM_TAPS(NUM_TAPS)) u_sel (
      .rst      (rst),
      .sel      (ch_sel[c]),
      .tap_stb  (tap_stb),
      .ext_rise (ext_rise[c]),
      .ext_fall (ext_fall[c]),
      .en       (cnt_en[c])
    );
  end

endmodule

// File: rtl/timer_presc_share_chk.sv
module timer_presc_share_chk #(
  parameter int NUM_CH   = 2,
  parameter int DIV_W    = 10,
  parameter int NUM_TAPS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   presc_clr,
  input logic [NUM_CH-1:0][2:0] ch_sel,
  input logic [NUM_CH-1:0]      ext_lvl,
  input logic [NUM_CH-1:0]      cnt_en,
  input logic [DIV_W-1:0]       div_cnt,
  input logic [NUM_TAPS-1:0]    tap_stb
);

  AST_RST_QUIET: assert property (@(posedge clk) rst |-> cnt_en == '0); // R1

  AST_DIV_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !presc_clr |=> div_cnt == DIV_W'($past(div_cnt) + 1'b1)); // R5

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    presc_clr |=> div_cnt == '0); // R7

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap_chk
    AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      tap_stb[k] |=> !tap_stb[k]); // R10
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    AST_OFF_QUIET: assert property (@(posedge clk)
      ch_sel[c] == 3'd0 |-> !cnt_en[c]); // R2
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
      ch_sel[c] == 3'd1 |-> cnt_en[c]); // R3
    AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (ch_sel[c] == 3'd7 && cnt_en[c]) |-> ext_lvl[c]); // R8
    AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (ch_sel[c] == 3'd6 && cnt_en[c]) |-> !ext_lvl[c]); // R8
  end

endmodule

bind timer_presc_share timer_presc_share_chk #(
  .NUM_CH(NUM_CH), .DIV_W(DIV_W), .NUM_TAPS(NUM_TAPS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .presc_clr (presc_clr),
  .ch_sel    (ch_sel),
  .ext_lvl   (ext_lvl),
  .cnt_en    (cnt_en),
  .div_cnt   (div_cnt),
  .tap_stb   (tap_stb)
);

// File: tb/timer_presc_share_bench.sv
module timer_presc_share_bench;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 2;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   presc_clr = 1'b0;
  logic [NUM_CH-1:0][2:0] ch_sel = '0;
  logic [NUM_CH-1:0]      ext_lvl = '0;
  logic [NUM_CH-1:0]      cnt_en;

  int vectors = 0;
  int miscompares = 0;

  // bench-side view of the divider and edge history, built from R5, R7, R8
  logic [9:0]        m_cnt = '0;
  logic [NUM_CH-1:0] m_prev = '0;
  logic [NUM_CH-1:0] last_en = '0;
  logic [NUM_CH-1:0][2:0] last_sel = '0;

  always #(CLK_P/2) clk = ~clk;

  timer_presc_share u_timer_presc_share (
    .clk(clk), .rst(rst), .presc_clr(presc_clr),
    .ch_sel(ch_sel), .ext_lvl(ext_lvl), .cnt_en(cnt_en)
  );

  always @(posedge clk) begin
    m_cnt  <= (rst || presc_clr) ? 10'd0 : m_cnt + 10'd1;
    m_prev <= ext_lvl;
  end

  function automatic bit exp_en(input logic [2:0] s, input logic [9:0] c,
                                input bit l, input bit p, input bit r);
    if (r) return 1'b0;
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return (c % 8)   == 7;
      3'd3: return (c % 64)  == 63;
      3'd4: return (c % 256) == 255;
      3'd5: return c == 10'd1023;
      3'd6: return p && !l;
      default: return !p && l;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input bit r);
    if (r) return "R1";
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3, 3'd4, 3'd5: return "R4/R5";
      default: return "R8";
    endcase
  endfunction

  // drive one cycle of inputs, then compare both channels against the model
  task automatic step(input bit r, input bit clr, input logic [2:0] s0,
                      input logic [2:0] s1, input logic [1:0] lv);
    @(negedge clk);
    rst = r; presc_clr = clr; ch_sel[0] = s0; ch_sel[1] = s1; ext_lvl = lv;
    #1;
    for (int c = 0; c < NUM_CH; c++) begin
      bit e;
      e = exp_en(ch_sel[c], m_cnt, ext_lvl[c], m_prev[c], rst);
      vectors++;
      if (cnt_en[c] !== e) begin
        miscompares++;
        $display("FAIL %s ch%0d sel=%0d: got %b expected %b",
                 tag_of(ch_sel[c], rst), c, ch_sel[c], cnt_en[c], e);
      end
      // R10: no back-to-back strobes for codes 2..7 with a steady select
      if (!rst && ch_sel[c] >= 3'd2 && ch_sel[c] == last_sel[c]) begin
        vectors++;
        if (cnt_en[c] && last_en[c]) begin
          miscompares++;
          $display("FAIL R10 ch%0d: got two strobes in a row expected one", c);
        end
      end
      last_en[c]  = cnt_en[c];
      last_sel[c] = ch_sel[c];
    end
  endtask

  task automatic expect_eq(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));

    // R1: reset, including a high external level and full-rate selects
    for (int i = 0; i < 4; i++) step(1, 0, 3'd1, 3'd7, 2'b11);

    // R7 + R5 + R9: clear, then ch0 idles on code 0 for 300 cycles before /1024
    begin
      int first0 = 0, first1 = 0;
      step(0, 1, 3'd0, 3'd2, 2'b00);
      for (int k = 1; k <= 1100; k++) begin
        step(0, 0, (k <= 300) ? 3'd0 : 3'd5, 3'd2, 2'b00);
        if (cnt_en[0] && first0 == 0) first0 = k;
        if (cnt_en[1] && first1 == 0) first1 = k;
      end
      expect_eq("R7 first /8 strobe after clear", first1, 8);
      expect_eq("R5 /1024 phase unaffected by select change", first0, 1024);
    end

    // R6: switch onto each tap at a random phase, first strobe within N cycles
    for (int t = 0; t < 4; t++) begin
      int n, k, hit;
      n = (t == 0) ? 8 : (t == 1) ? 64 : (t == 2) ? 256 : 1024;
      for (int i = 0; i < int'($urandom_range(1, 700)); i++)
        step(0, 0, 3'd0, 3'd1, 2'b00);
      hit = 0;
      k = 0;
      while (hit == 0 && k < n + 4) begin
        k++;
        step(0, 0, 3'(t + 2), 3'd1, 2'b00);
        if (cnt_en[0]) hit = k;
      end
      vectors++;
      if (hit < 1 || hit > n) begin
        miscompares++;
        $display("FAIL R6 tap %0d: got first strobe at %0d expected 1..%0d", n, hit, n);
      end
    end

    // R8: directed edges, both polarities on the two channels at once
    step(0, 0, 3'd7, 3'd6, 2'b00);
    step(0, 0, 3'd7, 3'd6, 2'b11);
    expect_eq("R8 rise strobe", int'(cnt_en[0]), 1);
    expect_eq("R8 no fall strobe on rise", int'(cnt_en[1]), 0);
    step(0, 0, 3'd7, 3'd6, 2'b00);
    expect_eq("R8 fall strobe", int'(cnt_en[1]), 1);

    // constrained random: slow select changes, rare clear and reset
    begin
      logic [2:0] s0 = 3'd2, s1 = 3'd5;
      logic [1:0] lv = 2'b00;
      for (int i = 0; i < 30000; i++) begin
        bit r, cl;
        if ($urandom_range(0, 299) == 0) s0 = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 299) == 0) s1 = 3'($urandom_range(0, 7));
        for (int c = 0; c < NUM_CH; c++)
          if ($urandom_range(0, 2) == 0) lv[c] = ~lv[c];
        cl = ($urandom_range(0, 1999) == 0);
        r  = ($urandom_range(0, 4999) == 0);
        step(r, cl, s0, s1, lv);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule